// File: doc/BRIEF.md
# Display-Link Register Target with DDC Handshake

This block is an I2C target that stands in for the register interface of a display transmitter. It samples SCL and SDA on the system clock through a short synchronizer. It pulls SDA low through an open-drain style output and output-enable pair, and it answers at a 7-bit address set by a parameter. The first data byte of every write transaction sets an internal 8-bit register pointer. Each data byte after that, read or written, moves the pointer on by one. A read that follows a repeated START, or that comes in a later transaction, continues from wherever the pointer stands.

Only three offsets return data. Offset 0x3D is a fixed interrupt-status value that reports a sink as plugged. Offset 0x1B is a fixed identity value. Offset 0x1A is the system-control register, and its read-back reflects a two-step handshake for the downstream display-data-channel bus. A write with the request bit (bit 2) set records a pending request. If the grant bit (bit 1) is set in the same write, the block also enters DDC mode, which it shows on a dedicated output. A write with the request bit clear drops both the request and DDC mode. Host software uses this handshake to switch the channel over before it reads the monitor's EDID from a separate device.

Top module: `disp_link_target`

## Requirements
- R1: The target ACKs an address byte whose upper 7 bits equal the address parameter. For any other address it never drives SDA until the next START.
- R2: The first data byte after an address with the write bit (bit 0 = 0) loads the register pointer and changes no register.
- R3: The pointer increases by one after every data byte written or read, and it wraps from 0xFF to 0x00.
- R4: Writing offset 0x1A with bit 2 and bit 1 both set raises ddc_mode, and reading offset 0x1A then returns 0x06.
- R5: Writing offset 0x1A with bit 2 set and bit 1 clear records the request, so offset 0x1A reads 0x06, and leaves ddc_mode as it was.
- R6: Writing offset 0x1A with bit 2 clear lowers ddc_mode and clears the request, so offset 0x1A reads 0x00.
- R7: Reading offset 0x1B always returns 0xB0.
- R8: Reading offset 0x3D always returns 0x04.
- R9: Every other offset reads 0x00. Writes to any offset other than 0x1A leave ddc_mode and the offset-0x1A read-back unchanged.
- R10: Reset sets the pointer to 0x00, clears the request and ddc_mode, and releases SDA.
- R11: The target ACKs every written data byte. On reads it sends the byte MSB first and releases SDA for the controller's acknowledge bit. After an ACK it sends the next byte; after a NACK it stops driving SDA. A read after a repeated START continues from the current pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_o | output | 1 | SDA drive value, always 0 (open drain) |
| sda_oe | output | 1 | High while the target pulls SDA low |
| ddc_mode | output | 1 | High while the display-data-channel bus is granted |

## Verification
The assertions assume one controller on the bus. They also assume SDA changes only while SCL is low, except at START and STOP, and that every SCL phase lasts longer than the synchronizer delay plus one clock. Under those conditions the target's SDA enable moves only just after an SCL fall, a START or a STOP. The bench's bit-banged controller holds each SCL quarter period for eight clocks and changes its SDA only in the middle of the low phase, so its random register traffic and directed sequences stay within these assumptions.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] CTRL_OFS  = 8'h1A;
  localparam logic [BYTE_W-1:0] IDENT_OFS = 8'h1B;
  localparam logic [BYTE_W-1:0] IRQ_OFS   = 8'h3D;

  localparam int REQ_BIT   = 2;
  localparam int GRANT_BIT = 1;

  localparam logic [BYTE_W-1:0] IDENT_VAL    = 8'hB0;
  localparam logic [BYTE_W-1:0] IRQ_VAL      = 8'h04;
  localparam logic [BYTE_W-1:0] CTRL_GRANTED = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WRX, ST_WACK, ST_RTX, ST_RACK
  } eng_state_e;

  function automatic logic [BYTE_W-1:0] reg_readback(input logic [BYTE_W-1:0] p,
                                                     input logic req);
    logic [BYTE_W-1:0] v;
    v = '0;
    if (p == CTRL_OFS && req) v = CTRL_GRANTED;
    else if (p == IDENT_OFS)  v = IDENT_VAL;
    else if (p == IRQ_OFS)    v = IRQ_VAL;
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p);
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/dlt_line_sync.sv
module dlt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dlt_byte_engine.sv
module dlt_byte_engine
  import dlt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic              wr_pulse,
  output logic              rd_pulse,
  output logic [BYTE_W-1:0] byte_q
);
  eng_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              drv, rw, first, nack;
  logic [BYTE_W-1:0] rx_byte;
  logic              last_bit;

  assign rx_byte  = {sh[BYTE_W-2:0], sda_s};
  assign last_bit = (cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      sda_oe <= 1'b0; drv <= 1'b0; rw <= 1'b0; first <= 1'b0; nack <= 1'b0;
      ptr_load <= 1'b0; wr_pulse <= 1'b0; rd_pulse <= 1'b0; byte_q <= '0;
    end else begin
      ptr_load <= 1'b0;
      wr_pulse <= 1'b0;
      rd_pulse <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; drv <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0; drv <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                state <= ST_AACK; rw <= rx_byte[0]; drv <= 1'b0;
              end else state <= ST_IDLE;
            end
          end
          ST_AACK, ST_WACK: if (scl_fall) begin
            if (!drv) begin
              sda_oe <= 1'b1; drv <= 1'b1;
            end else begin
              drv <= 1'b0; cnt <= '0;
              if (state == ST_AACK && rw) begin
                rd_pulse <= 1'b1; tx <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1]; state <= ST_RTX;
              end else begin
                sda_oe <= 1'b0; state <= ST_WRX;
                if (state == ST_AACK) first <= 1'b1;
              end
            end
          end
          ST_WRX: if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              byte_q <= rx_byte;
              if (first) ptr_load <= 1'b1;
              else       wr_pulse <= 1'b1;
              first <= 1'b0; drv <= 1'b0; state <= ST_WACK;
            end
          end
          ST_RTX: if (scl_fall) begin
            if (last_bit) begin
              sda_oe <= 1'b0; state <= ST_RACK;
            end else begin
              tx <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
              cnt <= cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) nack <= sda_s;
            if (scl_fall) begin
              if (!nack) begin
                rd_pulse <= 1'b1; tx <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1]; cnt <= '0; state <= ST_RTX;
              end else state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_OE_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R1
  AST_ONE_BYTE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ptr_load, wr_pulse, rd_pulse}) <= 1); // R2
endmodule

// File: rtl/dlt_regbank.sv
module dlt_regbank
  import dlt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic              wr_pulse,
  input  logic              rd_pulse,
  input  logic [BYTE_W-1:0] byte_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ddc_mode
);
  logic [BYTE_W-1:0] ptr;
  logic              ddc_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; ddc_req <= 1'b0; ddc_mode <= 1'b0;
    end else if (ptr_load) begin
      ptr <= byte_q;
    end else if (wr_pulse) begin
      if (ptr == CTRL_OFS) begin
        if (byte_q[REQ_BIT]) begin
          ddc_req <= 1'b1;
          if (byte_q[GRANT_BIT]) ddc_mode <= 1'b1;
        end else begin
          ddc_req  <= 1'b0;
          ddc_mode <= 1'b0;
        end
      end
      ptr <= ptr_step(ptr);
    end else if (rd_pulse) begin
      ptr <= ptr_step(ptr);
    end
  end

  assign rd_data = reg_readback(ptr, ddc_req);

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse || rd_pulse) |=> ptr == $past(ptr) + 8'd1); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr == $past(byte_q)); // R2
  AST_MODE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_mode |-> ddc_req); // R4
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && ptr == CTRL_OFS && !byte_q[REQ_BIT]) |=> !ddc_mode && !ddc_req); // R6
  AST_OTHER_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && ptr != CTRL_OFS) |=> $stable(ddc_mode) && $stable(ddc_req)); // R9
endmodule

// File: rtl/disp_link_target.sv
module disp_link_target
  import dlt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe,
  output logic ddc_mode
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_load, wr_pulse, rd_pulse;
  logic [BYTE_W-1:0] byte_q, rd_data;

  dlt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dlt_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr_load(ptr_load),
    .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .byte_q(byte_q)
  );

  dlt_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .wr_pulse(wr_pulse),
    .rd_pulse(rd_pulse), .byte_q(byte_q), .rd_data(rd_data), .ddc_mode(ddc_mode)
  );

  assign sda_o = 1'b0;
endmodule

// File: tb/sim_disp_link_target.sv
module sim_disp_link_target;
  localparam logic [6:0] DEV = 7'h39;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  wire  sda_o, sda_oe, ddc_mode;
  wire  sda_line = sda_m & ~(sda_oe & ~sda_o);

  always #4 clk = ~clk;

  disp_link_target #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .ddc_mode(ddc_mode)
  );

  int checks = 0, errors = 0;
  logic [7:0] m_ptr = 8'h00;
  logic       m_req = 1'b0, m_ddc = 1'b0;
  logic [7:0] wbuf [32];

  function automatic logic [7:0] want_read(input logic [7:0] p, input logic req);
    case (p)
      8'h3D:   return 8'h04;
      8'h1B:   return 8'hB0;
      8'h1A:   return req ? 8'h06 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] d);
    if (m_ptr == 8'h1A) begin
      if (!d[2]) begin m_req = 1'b0; m_ddc = 1'b0; end
      else begin m_req = 1'b1; if (d[1]) m_ddc = 1'b1; end
    end
    m_ptr = m_ptr + 8'd1;
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(1); scl_m = 1'b1; wait_q(1);
    sda_m = 1'b0; wait_q(1); scl_m = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(1); scl_m = 1'b1; wait_q(1); sda_m = 1'b1; wait_q(1);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q(1); scl_m = 1'b1; wait_q(2); scl_m = 1'b0; wait_q(1);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q(1); scl_m = 1'b1; wait_q(1);
    b = sda_line; wait_q(1); scl_m = 1'b0; wait_q(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input string tag);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); check8("R1 addr ack", {7'd0, a}, 8'd1);
    send_byte(p, a);           check8("R11 ptr ack", {7'd0, a}, 8'd1);
    m_ptr = p;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);   check8("R11 data ack", {7'd0, a}, 8'd1);
      model_write(wbuf[i]);
    end
    bus_stop();
    check8(tag, {7'd0, ddc_mode}, {7'd0, m_ddc});
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input logic set_ptr,
                         input string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, a); check8("R1 addr ack", {7'd0, a}, 8'd1);
      send_byte(p, a);           check8("R11 ptr ack", {7'd0, a}, 8'd1);
      m_ptr = p;
      bus_start();
    end
    send_byte({DEV, 1'b1}, a);   check8("R1 read addr ack", {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      check8(tag, d, want_read(m_ptr, m_req));
      m_ptr = m_ptr + 8'd1;
    end
    bus_stop();
    check8("R11 released after NACK", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    m_ptr = 8'h00; m_req = 1'b0; m_ddc = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    apply_reset();
    // R10: reset state at the ports
    check8("R10 sda_oe", {7'd0, sda_oe}, 8'd0);
    check8("R10 ddc_mode", {7'd0, ddc_mode}, 8'd0);
    do_read(8'h1A, 1, 1'b1, "R10 ctrl after reset");

    // R1: foreign address is never acknowledged
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    check8("R1 foreign addr", {7'd0, a}, 8'd0);
    send_byte(8'h1A, a);
    check8("R1 foreign data", {7'd0, a}, 8'd0);
    bus_stop();

    // R7, R8, R9: fixed read-back values, multi-byte read
    do_read(8'h1B, 1, 1'b1, "R7 identity");
    do_read(8'h3D, 1, 1'b1, "R8 irq status");
    do_read(8'h19, 4, 1'b1, "R9 sweep");

    // R4: request plus grant
    wbuf[0] = 8'h06; do_write(8'h1A, 1, "R4 ddc on");
    do_read(8'h1A, 1, 1'b1, "R4 ctrl read");
    // R5: request only keeps mode
    wbuf[0] = 8'h04; do_write(8'h1A, 1, "R5 mode kept high");
    do_read(8'h1A, 1, 1'b1, "R5 ctrl read");
    // R9: other-offset writes ignored
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; do_write(8'h1B, 2, "R9 ignored write");
    do_read(8'h1A, 1, 1'b1, "R9 ctrl unchanged");
    // R6: request clear drops everything
    wbuf[0] = 8'h02; do_write(8'h1A, 1, "R6 ddc off");
    do_read(8'h1A, 1, 1'b1, "R6 ctrl read");
    wbuf[0] = 8'h04; do_write(8'h1A, 1, "R5 mode kept low");
    do_read(8'h1A, 1, 1'b1, "R5 ctrl read low");

    // R2: pointer byte is not a register write; later read resumes at pointer
    wbuf[0] = 8'h00; do_write(8'h30, 0, "R2 pointer only");
    do_read(8'h00, 1, 1'b1, "R2 ctrl untouched");
    do_write(8'h1B, 0, "R2 set pointer");
    do_read(8'h00, 1, 1'b0, "R11 continue from pointer");

    // R3: write wraps past 0xFF and lands on 0x1A at byte 27
    for (int i = 0; i < 28; i++) wbuf[i] = (i == 27) ? 8'h06 : 8'h00;
    do_write(8'hFF, 28, "R3 write wrap");
    do_read(8'hFF, 29, 1'b1, "R3 read wrap");

    // R10: reset mid-run clears mode, request and pointer
    apply_reset();
    check8("R10 ddc after reset", {7'd0, ddc_mode}, 8'd0);
    do_read(8'h00, 28, 1'b0, "R10 pointer from zero");

    // random traffic
    for (int k = 0; k < 30; k++) begin
      logic [7:0] p;
      int n;
      case ($urandom_range(0, 3))
        0:       p = 8'h1A;
        1:       p = 8'h1B;
        2:       p = 8'h3D;
        default: p = 8'($urandom);
      endcase
      n = int'($urandom_range(1, 3));
      if ($urandom_range(0, 1) == 0) begin
        for (int i = 0; i < n; i++)
          wbuf[i] = ($urandom_range(0, 1) == 0) ? 8'(($urandom_range(0, 3)) << 1) : 8'($urandom);
        do_write(p, n, "R5 random write mode");
      end else begin
        do_read(p, n, $urandom_range(0, 3) != 0, "R9 random read");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule